// File: doc/BRIEF.md
# Two-Step Single-Slope Conversion Sequencer

This block is the digital sequencer of a 12-bit two-step single-slope converter. A start strobe begins a conversion. The block closes the sample and reference switches so the input is captured on the hold capacitor. It then runs a 6-bit coarse count that sets the coarse ramp. When the comparator rises, it freezes that count, opens the sample switch and runs a 7-bit fine count. The fine ramp spans two coarse steps, which gives a redundancy window around the coarse boundary.

The fine count is frozen on the next comparator rise. The two counts are merged as `coarse * 64 + fine`. The redundancy offset of 32 is then removed and the result is clamped to the 12-bit range. The result is published with a one-cycle valid pulse.

Both counter values leave the block on ports. An external ramp decoder and the injection-correction DAC use them. During the fine phase, the coarse value stays frozen on its port so the DAC keeps its code. The comparator output is expected to come from a clocked latch that is synchronous to `clk_i`.

Top module: `tsss_adc_ctrl`

## Requirements
- R1: While reset is applied and after it is released, every switch output is 0 (open), both counter outputs are 0, `result_o` is 0 and `result_valid_o` is 0.
- R2: A start strobe accepted while idle closes the sample and hold switches (value 1) with the fine switch open, for SAMP_CYC clock cycles. The sample and fine switches are never closed together, and neither are the hold and fine switches.
- R3: The coarse counter is cleared and then rises by exactly one per clock from 0, with the sample and hold switches still closed. It changes only by +1 or by returning to 0.
- R4: A comparator rising edge during the coarse phase freezes the coarse count as the coarse result, and the sample switch opens on the next clock. A comparator already high in the first counting cycle counts as a rising edge. The frozen value stays on `coarse_cnt_o` for the whole fine phase.
- R5: In the fine phase the hold switch is open and the fine switch is closed. The fine counter starts from 0 and counts up by one per clock, and a comparator rising edge freezes it as the fine result.
- R6: The result equals `coarse * 64 + fine - 32`, clamped to the range 0 to 4095.
- R7: When a counter reaches its all-ones value (63 coarse, 127 fine) without a comparator rise, that all-ones value is taken as the stage result. The counter never wraps.
- R8: `result_valid_o` is high for exactly one cycle per conversion. It rises SAMP_CYC + 5 + coarse + fine clock edges after the edge that samples the start strobe. `result_o` holds its value between pulses.
- R9: A start strobe arriving during a conversion has no effect. The conversion in flight keeps its timing and result, and no extra conversion follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start strobe |
| cmp_i | input | 1 | Comparator decision, synchronous to clk_i |
| sw_sample_o | output | 1 | Sample switch control, 1 = closed |
| sw_hold_o | output | 1 | Hold/reference switch control, 1 = closed |
| sw_fine_o | output | 1 | Fine ramp switch control, 1 = closed |
| coarse_cnt_o | output | 6 | Coarse counter, to the ramp decoder and the correction DAC |
| fine_cnt_o | output | 7 | Fine counter, to the fine ramp decoder |
| result_o | output | 12 | Corrected conversion result |
| result_valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The embedded assertions check, on every cycle, the switch properties: that sample and fine are never closed together, and that hold and fine are never closed together. They also check that each counter only steps by one or clears and never wraps, that a coarse rise opens the sample switch on the next clock, that the valid strobe is a single cycle, and that the result is stable between strobes. The arithmetic can only be shown by the bench's sweeps: the offset removal, clamping at both ends, and the fallback to the all-ones count. The same holds for the exact start-to-valid latency for every coarse value and every fine value, and for a start strobe during a conversion leaving the result and timing unchanged.

// File: rtl/tsss_pkg.sv
package tsss_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CRST,
    ST_COARSE,
    ST_FRST,
    ST_FINE,
    ST_DONE
  } phase_e;

endpackage

// File: rtl/tsss_counter.sv
// Synchronous up-counter with clear, enable and terminal-count flag.
module tsss_counter #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == MAXV);

  // R3: value moves only by +1 or back to zero
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + W'(1)));

  // R7: never asked to count past all-ones
  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && !clr_i && at_max_o));

endmodule

// File: rtl/tsss_edge.sv
// Rising-edge detector for the comparator; history cleared at phase entry.
module tsss_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  input  logic clr_i,
  output logic rise_o
);

  logic cmp_q, cmp_d;

  always_comb begin
    cmp_d = clr_i ? 1'b0 : cmp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_q <= 1'b0;
    else         cmp_q <= cmp_d;
  end

  assign rise_o = cmp_i & ~cmp_q;

endmodule

// File: rtl/tsss_seq.sv
// Phase sequencer: sampling, coarse count, fine count, result publication.
module tsss_seq
  import tsss_pkg::*;
#(
  parameter int SAMP_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rise_i,
  input  logic c_max_i,
  input  logic f_max_i,
  output logic c_clr_o,
  output logic c_en_o,
  output logic f_clr_o,
  output logic f_en_o,
  output logic edge_clr_o,
  output logic load_o,
  output logic sw_sample_o,
  output logic sw_hold_o,
  output logic sw_fine_o
);

  localparam int TW = (SAMP_CYC > 1) ? $clog2(SAMP_CYC) : 1;
  localparam logic [TW-1:0] TLOAD = TW'(SAMP_CYC - 1);

  phase_e state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;
  logic sw_s_q, sw_h_q, sw_f_q;
  logic sw_s_d, sw_h_d, sw_f_d;

  // next state
  always_comb begin
    state_d = state_q;
    tmr_en  = 1'b0;
    tmr_d   = tmr_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SAMPLE;
        tmr_en  = 1'b1;
        tmr_d   = TLOAD;
      end
      ST_SAMPLE: begin
        if (tmr_q == '0) state_d = ST_CRST;
        else begin
          tmr_en = 1'b1;
          tmr_d  = tmr_q - TW'(1);
        end
      end
      ST_CRST:   state_d = ST_COARSE;
      ST_COARSE: if (rise_i || c_max_i) state_d = ST_FRST;
      ST_FRST:   state_d = ST_FINE;
      ST_FINE:   if (rise_i || f_max_i) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // switch decode from next state, registered for glitch-free drive
  always_comb begin
    sw_s_d = (state_d == ST_SAMPLE) || (state_d == ST_CRST) || (state_d == ST_COARSE);
    sw_h_d = sw_s_d || (state_d == ST_FRST);
    sw_f_d = (state_d == ST_FINE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sw_s_q  <= 1'b0;
      sw_h_q  <= 1'b0;
      sw_f_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sw_s_q  <= sw_s_d;
      sw_h_q  <= sw_h_d;
      sw_f_q  <= sw_f_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  // counter and datapath controls
  always_comb begin
    c_clr_o    = (state_q == ST_IDLE) || (state_q == ST_SAMPLE) || (state_q == ST_CRST);
    c_en_o     = (state_q == ST_COARSE) && !rise_i && !c_max_i;
    f_clr_o    = (state_q == ST_IDLE) || (state_q == ST_FRST);
    f_en_o     = (state_q == ST_FINE) && !rise_i && !f_max_i;
    edge_clr_o = (state_q == ST_CRST) || (state_q == ST_FRST);
    load_o     = (state_q == ST_DONE);
  end

  assign sw_sample_o = sw_s_q;
  assign sw_hold_o   = sw_h_q;
  assign sw_fine_o   = sw_f_q;

  // R2: sample and fine never closed together
  a_r2_break_before_make: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_s_q && sw_f_q));

  // R5: hold reference and fine ramp never closed together
  a_r5_hold_fine_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_h_q && sw_f_q));

  // R4: coarse decision opens the sample switch on the next clock
  a_r4_sample_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COARSE && rise_i) |=> (!sw_s_q && state_q == ST_FRST));

  // R9: start during a conversion does not restart sampling
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_SAMPLE && start_i) |=> (state_q != ST_SAMPLE));

endmodule

// File: rtl/tsss_combine.sv
// Merge coarse and fine counts, remove redundancy offset, clamp, publish.
module tsss_combine #(
  parameter int CW     = 6,
  parameter int FW     = 7,
  parameter int OUT_W  = 12,
  parameter int OFFSET = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CW-1:0]    coarse_i,
  input  logic [FW-1:0]    fine_i,
  output logic [OUT_W-1:0] result_o,
  output logic             valid_o
);

  localparam int SHIFT = OUT_W - CW;
  localparam int RW    = OUT_W + 2;
  localparam logic [RW-1:0] OFS  = RW'(OFFSET);
  localparam logic [RW-1:0] TOPV = RW'((1 << OUT_W) - 1);

  logic [RW-1:0]    raw, diff;
  logic [OUT_W-1:0] sat;
  logic [OUT_W-1:0] res_q, res_d;
  logic             vld_q;

  always_comb begin
    raw  = (RW'(coarse_i) << SHIFT) + RW'(fine_i);
    diff = raw - OFS;
    if (raw < OFS)        sat = '0;
    else if (diff > TOPV) sat = {OUT_W{1'b1}};
    else                  sat = diff[OUT_W-1:0];
    res_d = load_i ? sat : res_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= load_i;
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;

  // R8: single-cycle strobe
  a_r8_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);

  // R8: result only changes together with a strobe
  a_r8_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q |-> $stable(res_q));

endmodule

// File: rtl/tsss_adc_ctrl.sv
// Top: two-step single-slope conversion sequencer.
module tsss_adc_ctrl #(
  parameter int CW       = 6,
  parameter int FW       = 7,
  parameter int OUT_W    = 12,
  parameter int OFFSET   = 32,
  parameter int SAMP_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             sw_sample_o,
  output logic             sw_hold_o,
  output logic             sw_fine_o,
  output logic [CW-1:0]    coarse_cnt_o,
  output logic [FW-1:0]    fine_cnt_o,
  output logic [OUT_W-1:0] result_o,
  output logic             result_valid_o
);

  logic rst_meta_q, rst_sync_q, rst_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_n = rst_sync_q;

  logic rise, c_max, f_max;
  logic c_clr, c_en, f_clr, f_en, edge_clr, load;

  tsss_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .cmp_i  (cmp_i),
    .clr_i  (edge_clr),
    .rise_o (rise)
  );

  tsss_seq #(.SAMP_CYC(SAMP_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .start_i     (start_i),
    .rise_i      (rise),
    .c_max_i     (c_max),
    .f_max_i     (f_max),
    .c_clr_o     (c_clr),
    .c_en_o      (c_en),
    .f_clr_o     (f_clr),
    .f_en_o      (f_en),
    .edge_clr_o  (edge_clr),
    .load_o      (load),
    .sw_sample_o (sw_sample_o),
    .sw_hold_o   (sw_hold_o),
    .sw_fine_o   (sw_fine_o)
  );

  tsss_counter #(.W(CW)) u_coarse (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .clr_i    (c_clr),
    .en_i     (c_en),
    .cnt_o    (coarse_cnt_o),
    .at_max_o (c_max)
  );

  tsss_counter #(.W(FW)) u_fine (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .clr_i    (f_clr),
    .en_i     (f_en),
    .cnt_o    (fine_cnt_o),
    .at_max_o (f_max)
  );

  tsss_combine #(.CW(CW), .FW(FW), .OUT_W(OUT_W), .OFFSET(OFFSET)) u_comb (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .load_i   (load),
    .coarse_i (coarse_cnt_o),
    .fine_i   (fine_cnt_o),
    .result_o (result_o),
    .valid_o  (result_valid_o)
  );

  // R4: coarse result frozen while the fine ramp runs
  a_r4_coarse_frozen: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sw_fine_o && $past(sw_fine_o)) |-> $stable(coarse_cnt_o));

endmodule

// File: tb/tsss_adc_ctrl_tb_top.sv
module tsss_adc_ctrl_tb_top;

  localparam int S = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic cmp;
  logic sw_s, sw_h, sw_f;
  logic [5:0]  ccnt;
  logic [6:0]  fcnt;
  logic [11:0] res;
  logic        vld;

  int ct, ft;
  int n_chk, n_bad;

  always #10 clk = ~clk;

  // behavioural comparator: trips when the running count reaches the target
  always_comb begin
    if (sw_f)      cmp = (int'(fcnt) >= ft);
    else if (sw_s) cmp = (int'(ccnt) >= ct);
    else           cmp = 1'b0;
  end

  tsss_adc_ctrl #(.SAMP_CYC(S)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .start_i        (start),
    .cmp_i          (cmp),
    .sw_sample_o    (sw_s),
    .sw_hold_o      (sw_h),
    .sw_fine_o      (sw_f),
    .coarse_cnt_o   (ccnt),
    .fine_cnt_o     (fcnt),
    .result_o       (res),
    .result_valid_o (vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_code(input int c, input int f);
    int v;
    v = c * 64 + f - 32;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  // one conversion; extra_start pulses start again mid-conversion (R9)
  task automatic convert(input int c_t, input int f_t, input bit extra_start);
    int c_e, f_e, k, lat;
    bit samp_ok, fine_ok, cstep_ok, fstart_ok, seen_fine;
    int prev_c;
    c_e = (c_t > 63) ? 63 : c_t;
    f_e = (f_t > 127) ? 127 : f_t;
    ct = c_t;
    ft = f_t;
    lat = S + 5 + c_e + f_e;
    samp_ok = 1; fine_ok = 1; cstep_ok = 1; fstart_ok = 1; seen_fine = 0;
    prev_c = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!vld && k < 1000) begin
      if (k <= S && !(sw_s && sw_h && !sw_f)) samp_ok = 0;
      if (sw_s && k > S) begin
        if (int'(ccnt) != prev_c && int'(ccnt) != prev_c + 1) cstep_ok = 0;
        prev_c = int'(ccnt);
      end
      if (sw_f) begin
        if (sw_h || sw_s || int'(ccnt) != c_e) fine_ok = 0;
        if (!seen_fine && fcnt != 0) fstart_ok = 0;
        seen_fine = 1;
      end
      if (extra_start && k == 10) start = 1'b1;
      if (extra_start && k == 11) start = 1'b0;
      @(negedge clk);
      k++;
    end
    chk(vld, "R8 watchdog/valid seen", k, lat + 1);
    chk(k == lat + 1, "R8 latency", k - 1, lat);
    chk(int'(res) == expect_code(c_e, f_e), "R6 result", int'(res), expect_code(c_e, f_e));
    chk(samp_ok, "R2 sampling switches", 0, 1);
    chk(cstep_ok, "R3 coarse count step", 0, 1);
    chk(fine_ok && seen_fine, "R4/R5 fine-phase switches and frozen coarse", 0, 1);
    chk(fstart_ok, "R5 fine count starts at 0", 0, 1);
    @(negedge clk);
    chk(!vld, "R8 one-cycle valid", int'(vld), 0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    start = 1'b0;
    ct = 0;
    ft = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sw_s && !sw_h && !sw_f, "R1 switches in reset", int'({sw_s, sw_h, sw_f}), 0);
    chk(ccnt == 0 && fcnt == 0, "R1 counters in reset", int'(ccnt) + int'(fcnt), 0);
    chk(res == 0 && !vld, "R1 result in reset", int'(res), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sw_s && !sw_h && !sw_f && !vld && res == 0, "R1 after release", int'(res), 0);

    // coarse sweep, varied fine (R3, R4, R6)
    for (int c = 0; c < 64; c++) convert(c, (c * 37) % 128, 1'b0);
    // fine sweep (R5, R6)
    for (int f = 0; f < 128; f++) convert(5, f, 1'b0);
    // clamp boundaries (R6)
    convert(0, 0, 1'b0);
    convert(0, 32, 1'b0);
    convert(0, 33, 1'b0);
    convert(63, 94, 1'b0);
    convert(63, 95, 1'b0);
    convert(63, 96, 1'b0);
    // no comparator rise (R7)
    convert(70, 10, 1'b0);
    convert(20, 200, 1'b0);
    convert(90, 300, 1'b0);
    // start while busy (R9)
    convert(17, 44, 1'b1);
    begin
      bit quiet;
      quiet = 1;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (vld || sw_s || sw_h || sw_f) quiet = 0;
      end
      chk(quiet, "R9 no extra conversion", 0, 1);
      chk(int'(res) == expect_code(17, 44), "R9 result kept", int'(res), expect_code(17, 44));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule